// File: doc/BRIEF.md
# Calendar Time Counter with BCD/Binary and 12/24-Hour Modes

This block holds the time of day and the calendar date in seven byte-wide fields: seconds, minutes, hours, day of week, day of month, month and a two-digit year. Each pulse on the one-second tick input advances the seconds field. A field that rolls over carries into the field above it, from the seconds up to the year. Month lengths and a leap-year rule set when the day of month wraps.

Two run-time selects set the format of the stored fields. One chooses packed BCD or plain binary for every field. The other chooses a 24-hour hour field or a 12-hour hour field with a PM flag. The counter never converts stored values when a select changes. It assumes that the host loaded values that are valid for the chosen format.

A freeze input stops all counting. While it is high, the host can write any single field through the load port without racing an update. Loaded values are stored exactly as given, with no range check and no correction.

Top module: `rtc_calendar_counter`

## Requirements
- R1: After reset the seconds, minutes, hours and year fields read 0, and the day of week, day of month and month fields read 1.
- R2: A cycle with tick_i=1 and freeze_i=0 advances the seconds field by one. Seconds go from 59 to 0 and carry into the minutes. Minutes go from 59 to 0 and carry into the hours.
- R3: With hour12_i=0 the hour field counts 0 to 23. The step from 23 to 0 produces the day carry.
- R4: With hour12_i=1, hour bit 7 is the PM flag and bits 6:0 hold the hour 1 to 12. The step from 12 goes to 1 with the flag unchanged. The step from 11 goes to 12 and toggles the flag. The day carry occurs only on the step from 11 PM to 12 AM.
- R5: With bcd_i=1 every field is packed BCD, with the tens digit in bits 7:4 and the units digit in bits 3:0. With bcd_i=0 every field is an unsigned binary number.
- R6: The day of week counts 1 to 7. On each day carry it advances, and it wraps from 7 to 1.
- R7: The day of month wraps to 1 and carries into the month after the last day of the month. That last day is 31 for months 1, 3, 5, 7, 8, 10 and 12, and 30 for months 4, 6, 9 and 11.
- R8: February ends on day 29 when the decimal year value is divisible by 4, and on day 28 otherwise, with no century exception. In BCD mode, year 0x12 is a leap year and year 0x10 is not.
- R9: The month wraps from 12 to 1 and carries into the year. The year wraps from 99 to 0.
- R10: While freeze_i=1, no field changes on a tick.
- R11: A cycle with freeze_i=1 and load_en_i=1 stores load_data_i unchanged into the field picked by load_sel_i, and no range check is applied. The select codes are 0 seconds, 1 minutes, 2 hours, 3 day of week, 4 day of month, 5 month and 6 year. Code 7 writes nothing.
- R12: A load request with freeze_i=0 is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| tick_i | input | 1 | One-second advance pulse |
| freeze_i | input | 1 | Stops counting and enables loads |
| bcd_i | input | 1 | 1 = packed BCD fields, 0 = binary |
| hour12_i | input | 1 | 1 = 12-hour with PM flag, 0 = 24-hour |
| load_en_i | input | 1 | Field write strobe |
| load_sel_i | input | 3 | Field select for the write |
| load_data_i | input | 8 | Value to write |
| sec_o | output | 8 | Seconds field |
| min_o | output | 8 | Minutes field |
| hour_o | output | 8 | Hours field |
| dow_o | output | 8 | Day-of-week field |
| dom_o | output | 8 | Day-of-month field |
| mon_o | output | 8 | Month field |
| year_o | output | 8 | Year field |

## Verification
The bench walks two full years day by day, from the first of January of year 99 through year 0, in both encodings. A wrong month table or a wrong leap rule would show up as a date such as the 31st of April or a missing 29th of February. It also wraps the year to 0 and the week from 7 to 1. The bench checks BCD years 0x10 and 0x12 on purpose. A design that tested divisibility on the raw byte instead of the decimal value would give the leap day to the wrong one of them. It steps a 25-hour sequence in all four mode combinations, and a wrong hour step would appear as a PM flag that toggles at 12 to 1 instead of at 11 to 12, or as a day carried at noon. It also checks that frozen ticks, loads made while running and the unused select code leave every field unchanged, and that an out-of-range load reads back unmodified.

// File: rtl/rtc_cal_pkg.sv
package rtc_cal_pkg;
  localparam int FW    = 8;
  localparam int NF    = 7;
  localparam int SEL_W = 3;

  typedef logic [FW-1:0] fw_t;

  localparam int F_SEC  = 0;
  localparam int F_MIN  = 1;
  localparam int F_HOUR = 2;
  localparam int F_DOW  = 3;
  localparam int F_DOM  = 4;
  localparam int F_MON  = 5;
  localparam int F_YEAR = 6;

  function automatic fw_t to_bin(fw_t v, logic bcd);
    fw_t hi, lo;
    hi = {4'd0, v[7:4]};
    lo = {4'd0, v[3:0]};
    return bcd ? fw_t'(hi * 8'd10 + lo) : v;
  endfunction

  function automatic fw_t from_bin(fw_t n, logic bcd);
    fw_t tens, ones;
    tens = n / 8'd10;
    ones = n - fw_t'(tens * 8'd10);
    return bcd ? fw_t'((tens << 4) | ones) : n;
  endfunction

  function automatic fw_t rst_val(int idx);
    return (idx == F_DOW || idx == F_DOM || idx == F_MON) ? fw_t'(1) : fw_t'(0);
  endfunction
endpackage

// File: rtl/rtc_cal_step.sv
module rtc_cal_step
  import rtc_cal_pkg::*;
(
  input  fw_t  val_i,
  input  logic bcd_i,
  input  logic inc_i,
  input  fw_t  lo_i,
  input  fw_t  hi_i,
  output fw_t  nxt_o,
  output logic carry_o
);
  fw_t  bin;
  logic at_top;
  fw_t  stepped;

  assign bin     = to_bin(val_i, bcd_i);
  assign at_top  = (bin == hi_i);
  assign stepped = at_top ? lo_i : fw_t'(bin + 8'd1);
  assign carry_o = inc_i & at_top;
  assign nxt_o   = inc_i ? from_bin(stepped, bcd_i) : val_i;
endmodule

// File: rtl/rtc_cal_hour.sv
module rtc_cal_hour
  import rtc_cal_pkg::*;
(
  input  fw_t  val_i,
  input  logic bcd_i,
  input  logic h12_i,
  input  logic inc_i,
  output fw_t  nxt_o,
  output logic day_o
);
  fw_t  h24, h12, nh, enc;
  logic pm;

  assign h24 = to_bin(val_i, bcd_i);
  assign h12 = to_bin({1'b0, val_i[6:0]}, bcd_i);

  always_comb begin
    nh    = '0;
    pm    = val_i[7];
    day_o = 1'b0;
    if (h12_i) begin
      if (h12 == 8'd12) begin
        nh = 8'd1;
      end else if (h12 == 8'd11) begin
        nh    = 8'd12;
        pm    = ~val_i[7];
        day_o = inc_i & val_i[7];
      end else begin
        nh = h12 + 8'd1;
      end
    end else begin
      if (h24 == 8'd23) begin
        nh    = 8'd0;
        day_o = inc_i;
      end else begin
        nh = h24 + 8'd1;
      end
    end
  end

  assign enc = from_bin(nh, bcd_i);

  always_comb begin
    if (!inc_i)     nxt_o = val_i;
    else if (h12_i) nxt_o = {pm, 7'd0} | (enc & 8'h7F);
    else            nxt_o = enc;
  end
endmodule

// File: rtl/rtc_cal_mlen.sv
module rtc_cal_mlen
  import rtc_cal_pkg::*;
(
  input  fw_t  mon_i,
  input  fw_t  year_i,
  input  logic bcd_i,
  output fw_t  len_o
);
  fw_t  mb, yb;
  logic leap;

  assign mb   = to_bin(mon_i, bcd_i);
  assign yb   = to_bin(year_i, bcd_i);
  assign leap = ((yb & 8'd3) == 8'd0);

  always_comb begin
    case (mb)
      8'd2:                      len_o = leap ? 8'd29 : 8'd28;
      8'd4, 8'd6, 8'd9, 8'd11:   len_o = 8'd30;
      default:                   len_o = 8'd31;
    endcase
  end
endmodule

// File: rtl/rtc_calendar_counter.sv
module rtc_calendar_counter
  import rtc_cal_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_i,
  input  logic             freeze_i,
  input  logic             bcd_i,
  input  logic             hour12_i,
  input  logic             load_en_i,
  input  logic [SEL_W-1:0] load_sel_i,
  input  logic [FW-1:0]    load_data_i,
  output logic [FW-1:0]    sec_o,
  output logic [FW-1:0]    min_o,
  output logic [FW-1:0]    hour_o,
  output logic [FW-1:0]    dow_o,
  output logic [FW-1:0]    dom_o,
  output logic [FW-1:0]    mon_o,
  output logic [FW-1:0]    year_o
);
  fw_t  fld_q [NF];
  fw_t  nxt   [NF];
  fw_t  dom_len;
  logic run, load_fire;
  logic cy_sec, cy_min, cy_day, cy_dom, cy_mon;
  logic unused_cy_dow, unused_cy_year;
  logic [NF*FW-1:0] all_q;

  assign run       = tick_i & ~freeze_i;
  assign load_fire = load_en_i & freeze_i;

  rtc_cal_step u_sec (
    .val_i(fld_q[F_SEC]), .bcd_i(bcd_i), .inc_i(run),
    .lo_i(8'd0), .hi_i(8'd59), .nxt_o(nxt[F_SEC]), .carry_o(cy_sec));

  rtc_cal_step u_min (
    .val_i(fld_q[F_MIN]), .bcd_i(bcd_i), .inc_i(cy_sec),
    .lo_i(8'd0), .hi_i(8'd59), .nxt_o(nxt[F_MIN]), .carry_o(cy_min));

  rtc_cal_hour u_hour (
    .val_i(fld_q[F_HOUR]), .bcd_i(bcd_i), .h12_i(hour12_i), .inc_i(cy_min),
    .nxt_o(nxt[F_HOUR]), .day_o(cy_day));

  rtc_cal_step u_dow (
    .val_i(fld_q[F_DOW]), .bcd_i(bcd_i), .inc_i(cy_day),
    .lo_i(8'd1), .hi_i(8'd7), .nxt_o(nxt[F_DOW]), .carry_o(unused_cy_dow));

  rtc_cal_mlen u_mlen (
    .mon_i(fld_q[F_MON]), .year_i(fld_q[F_YEAR]), .bcd_i(bcd_i), .len_o(dom_len));

  rtc_cal_step u_dom (
    .val_i(fld_q[F_DOM]), .bcd_i(bcd_i), .inc_i(cy_day),
    .lo_i(8'd1), .hi_i(dom_len), .nxt_o(nxt[F_DOM]), .carry_o(cy_dom));

  rtc_cal_step u_mon (
    .val_i(fld_q[F_MON]), .bcd_i(bcd_i), .inc_i(cy_dom),
    .lo_i(8'd1), .hi_i(8'd12), .nxt_o(nxt[F_MON]), .carry_o(cy_mon));

  rtc_cal_step u_year (
    .val_i(fld_q[F_YEAR]), .bcd_i(bcd_i), .inc_i(cy_mon),
    .lo_i(8'd0), .hi_i(8'd99), .nxt_o(nxt[F_YEAR]), .carry_o(unused_cy_year));

  for (genvar i = 0; i < NF; i++) begin : g_fld
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                                       fld_q[i] <= rst_val(i);
      else if (load_fire && load_sel_i == SEL_W'(i))     fld_q[i] <= load_data_i;
      else if (!freeze_i)                                fld_q[i] <= nxt[i];
    end
    assign all_q[i*FW +: FW] = fld_q[i];
  end

  assign sec_o  = fld_q[F_SEC];
  assign min_o  = fld_q[F_MIN];
  assign hour_o = fld_q[F_HOUR];
  assign dow_o  = fld_q[F_DOW];
  assign dom_o  = fld_q[F_DOM];
  assign mon_o  = fld_q[F_MON];
  assign year_o = fld_q[F_YEAR];

  AST_FREEZE_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (freeze_i && !load_en_i) |=> $stable(all_q)); // R10

  AST_LOAD_IGNORED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!freeze_i && load_en_i && !tick_i) |=> $stable(all_q)); // R12

  AST_LOAD_TAKE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (load_fire && load_sel_i == 3'd0) |=> (sec_o == $past(load_data_i))); // R11

  AST_SEC_WRAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run && to_bin(sec_o, bcd_i) == 8'd59) |=> (sec_o == 8'd0)); // R2

  AST_PM_TOGGLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hour12_i && $past(hour12_i) && $stable(bcd_i) && !$past(load_fire)
     && hour_o[7] != $past(hour_o[7]))
    |-> (hour_o[6:0] == (bcd_i ? 7'h12 : 7'd12))); // R4

  AST_DOW_NONZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(run) && !$past(load_fire) && $past(dow_o) == 8'd7 && dow_o != 8'd7)
    |-> (dow_o == 8'd1)); // R6
endmodule

// File: tb/rtc_calendar_counter_tb.sv
module rtc_calendar_counter_tb;
  logic       clk = 0, rst_n = 0;
  logic       tick = 0, freeze = 0, bcd = 0, h12 = 0, load_en = 0;
  logic [2:0] sel = 0;
  logic [7:0] data = 0;
  logic [7:0] sec_o, min_o, hour_o, dow_o, dom_o, mon_o, year_o;

  int errors = 0, checks = 0;
  bit done = 0;
  int b_sec, b_min, b_hr, b_dow, b_dom, b_mon, b_yr;

  always #5 clk = ~clk;

  rtc_calendar_counter u_dut (
    .clk_i(clk), .rst_ni(rst_n), .tick_i(tick), .freeze_i(freeze),
    .bcd_i(bcd), .hour12_i(h12), .load_en_i(load_en), .load_sel_i(sel),
    .load_data_i(data), .sec_o(sec_o), .min_o(min_o), .hour_o(hour_o),
    .dow_o(dow_o), .dom_o(dom_o), .mon_o(mon_o), .year_o(year_o));

  function automatic logic [7:0] enc(int n);
    return bcd ? 8'(((n / 10) << 4) | (n % 10)) : 8'(n);
  endfunction

  function automatic logic [7:0] enc_hr(int h);
    int v;
    if (!h12) return enc(h);
    v = (h % 12 == 0) ? 12 : h % 12;
    return {(h >= 12), 7'(enc(v))};
  endfunction

  function automatic int mlen(int m, int y);
    if (m == 2) return (y % 4 == 0) ? 29 : 28;
    if (m == 4 || m == 6 || m == 9 || m == 11) return 30;
    return 31;
  endfunction

  task automatic model_tick();
    b_sec++;
    if (b_sec == 60) begin
      b_sec = 0; b_min++;
      if (b_min == 60) begin
        b_min = 0; b_hr++;
        if (b_hr == 24) begin
          b_hr = 0;
          b_dow = (b_dow == 7) ? 1 : b_dow + 1;
          b_dom++;
          if (b_dom > mlen(b_mon, b_yr)) begin
            b_dom = 1; b_mon++;
            if (b_mon == 13) begin
              b_mon = 1;
              b_yr = (b_yr == 99) ? 0 : b_yr + 1;
            end
          end
        end
      end
    end
  endtask

  task automatic chk(string tag);
    logic [55:0] act, exp_v;
    act   = {sec_o, min_o, hour_o, dow_o, dom_o, mon_o, year_o};
    exp_v = {enc(b_sec), enc(b_min), enc_hr(b_hr), enc(b_dow), enc(b_dom), enc(b_mon), enc(b_yr)};
    checks++;
    if (act !== exp_v) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp_v);
    end
  endtask

  task automatic chk8(string tag, logic [7:0] act, logic [7:0] exp_v);
    checks++;
    if (act !== exp_v) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp_v);
    end
  endtask

  task automatic ld(int s, logic [7:0] v);
    @(negedge clk);
    freeze = 1; load_en = 1; sel = 3'(s); data = v;
    @(negedge clk);
    load_en = 0;
  endtask

  task automatic load_all();
    ld(0, enc(b_sec)); ld(1, enc(b_min)); ld(2, enc_hr(b_hr));
    ld(3, enc(b_dow)); ld(4, enc(b_dom)); ld(5, enc(b_mon)); ld(6, enc(b_yr));
  endtask

  task automatic run_tick(string tag);
    @(negedge clk);
    freeze = 0; tick = 1;
    @(negedge clk);
    tick = 0;
    model_tick();
    chk(tag);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    b_sec = 0; b_min = 0; b_hr = 0; b_dow = 1; b_dom = 1; b_mon = 1; b_yr = 0;
    repeat (3) @(negedge clk);
    chk("R1 during reset");
    rst_n = 1;
    @(negedge clk);
    chk("R1 after reset");

    // seconds/minutes sweep and hour sweep in all four modes
    for (int m = 0; m < 4; m++) begin
      bcd = m[0]; h12 = m[1];
      b_sec = 0; b_min = 0; b_hr = 0; b_dow = 3; b_dom = 5; b_mon = 6; b_yr = 21;
      load_all();
      chk("R11 load all");
      for (int t = 0; t < 3601; t++) run_tick("R2 R5 sec/min sweep");
      b_hr = 0;
      ld(2, enc_hr(b_hr));
      for (int h = 0; h < 25; h++) begin
        b_min = 59; b_sec = 59;
        ld(1, enc(59)); ld(0, enc(59));
        run_tick(h12 ? "R4 12h hour step" : "R3 24h hour step");
      end
    end

    // day sweep across two years, both encodings
    h12 = 0;
    for (int m = 0; m < 2; m++) begin
      bcd = m[0];
      b_sec = 59; b_min = 59; b_hr = 23; b_dow = 7; b_dom = 1; b_mon = 1; b_yr = 99;
      load_all();
      for (int d = 0; d < 731; d++) begin
        b_sec = 59; b_min = 59; b_hr = 23;
        ld(2, enc_hr(23)); ld(1, enc(59)); ld(0, enc(59));
        run_tick("R6 R7 R8 R9 day sweep");
      end
    end

    // BCD leap decision on the decimal value
    bcd = 1;
    b_sec = 59; b_min = 59; b_hr = 23; b_dow = 2; b_dom = 28; b_mon = 2; b_yr = 12;
    load_all();
    run_tick("R8 bcd year 12 leap");
    chk8("R8 bcd year 12 day", dom_o, 8'h29);
    b_sec = 59; b_min = 59; b_hr = 23; b_dom = 28; b_mon = 2; b_yr = 10;
    load_all();
    run_tick("R8 bcd year 10 not leap");
    chk8("R8 bcd year 10 month", mon_o, 8'h03);

    // freeze holds everything
    @(negedge clk);
    freeze = 1; tick = 1;
    repeat (6) @(negedge clk);
    tick = 0;
    chk("R10 frozen ticks");

    // load while running is ignored
    @(negedge clk);
    freeze = 0; load_en = 1; sel = 3'd0; data = 8'h33;
    @(negedge clk);
    load_en = 0; sel = 3'd4;
    @(negedge clk);
    chk("R12 load while running");

    // unused select code writes nothing
    ld(7, 8'h55);
    chk("R11 select 7 no write");

    // out-of-range load stored as-is
    ld(4, 8'h45);
    chk8("R11 raw dom load", dom_o, 8'h45);
    ld(0, 8'hFE);
    chk8("R11 raw sec load", sec_o, 8'hFE);

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule